// File: doc/BRIEF.md
# Event-Count Interrupt Prescaler

This block sits beside a PWM time-base and turns its event strobes into a paced interrupt. The time-base supplies one-cycle strobes for counter-at-zero, counter-at-period, and the two compare matches, each split by count direction. A 3-bit select routes one of them to a small event counter. When the counter reaches a programmed period of one, two or three events, the block sets a sticky pending flag. It also pulses the interrupt output for one cycle and clears the counter.

Software holds off further interrupts simply by leaving the flag set. A clear strobe re-arms the block. A force strobe raises an interrupt at once. The period can be rewritten at any time, and the rules for a write that lands at, below or together with the live count are fixed. All outputs are registered, and each takes effect on the clock edge that samples the inputs.

Top module: `evt_irq_prescaler`

## Requirements
- R1: The source select picks the counted event. Code 3'b001 selects counter-at-zero, 3'b010 counter-at-period, 3'b100 compare A counting up, 3'b101 compare A counting down, 3'b110 compare B counting up, and 3'b111 compare B counting down. Codes 3'b000 and 3'b011 select nothing. Strobes that are not selected leave count_o unchanged.
- R2: irq_o is never raised while irq_en_i is low, including for a force strobe. Selected events are still counted while it is low.
- R3: The period code sets how many events raise an interrupt: 2'b01 means one event, 2'b10 two, 2'b11 three. Suppose the count reaches a nonzero period while the block is enabled and the flag is clear. After that edge, irq_o is high for exactly one cycle, flag_o is 1 and count_o is 0.
- R4: With period code 2'b00, events are not counted, the force strobe is ignored and no interrupt is raised. The period code is 2'b00 after reset.
- R5: While flag_o is 1, no interrupt is raised. The count still advances up to the period and then holds there.
- R6: flag_clr_i clears flag_o on the next edge. If the count then equals a nonzero period and the block is enabled, the interrupt follows on the edge after that.
- R7: force_i raises an interrupt regardless of the count, provided the block is enabled, the flag is clear and the period is nonzero. The count is cleared.
- R8: Writing a period equal to the current count raises an interrupt if the block is enabled and the flag is clear.
- R9: An event in the same cycle as a period write is counted against the newly written period. It increments the count if the count is below that period.
- R10: After a period is written below the current count, the count holds and no interrupt is raised.
- R11: Reset (asynchronous, active low) gives irq_o=0, flag_o=0 and count_o=0. count_o only ever steps up by one or returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_zero_i | input | 1 | Time-base counter equals zero strobe |
| evt_prd_i | input | 1 | Time-base counter equals period strobe |
| evt_cmpa_up_i | input | 1 | Compare A match while counting up |
| evt_cmpa_dn_i | input | 1 | Compare A match while counting down |
| evt_cmpb_up_i | input | 1 | Compare B match while counting up |
| evt_cmpb_dn_i | input | 1 | Compare B match while counting down |
| src_sel_i | input | 3 | Event source select code |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Pending flag clear strobe |
| force_i | input | 1 | Software force strobe |
| prd_wr_i | input | 1 | Period write strobe |
| prd_wdata_i | input | CNT_W | Period code to write |
| irq_o | output | 1 | One-cycle interrupt pulse |
| flag_o | output | 1 | Sticky pending flag |
| count_o | output | CNT_W | Current event count |

## Verification
The bench targets the interlock. Events keep arriving while the flag is set, and the flag is then cleared with the count already at the period. A design that ignored the flag would fire twice. A design that lost the held count would never fire after the clear.

It also writes the period equal to the count, below it, and together with an event. A design comparing against the old period would miss the coincident increment or fire late. One that wrapped the count would fire spuriously.

Reserved select codes, unselected strobes, a zero period with a force strobe, and a force while disabled are all driven. A leaky select or a force gate missing any one term shows up as an unexpected pulse or count.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int SEL_W   = 3;
    localparam int NUM_SRC = 6;

    // strobe vector bit positions
    localparam int STB_ZERO   = 0;
    localparam int STB_PRD    = 1;
    localparam int STB_A_UP   = 2;
    localparam int STB_A_DN   = 3;
    localparam int STB_B_UP   = 4;
    localparam int STB_B_DN   = 5;

    typedef enum logic [SEL_W-1:0] {
        SRC_NONE0 = 3'b000,
        SRC_ZERO  = 3'b001,
        SRC_PRD   = 3'b010,
        SRC_NONE3 = 3'b011,
        SRC_A_UP  = 3'b100,
        SRC_A_DN  = 3'b101,
        SRC_B_UP  = 3'b110,
        SRC_B_DN  = 3'b111
    } evt_src_e;

endpackage

// File: rtl/evt_src_sel.sv
module evt_src_sel
    import evt_irq_pkg::*;
(
    input  logic [NUM_SRC-1:0] strobe_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               evt_o
);

    evt_src_e sel_e;

    always_comb begin
        sel_e = evt_src_e'(sel_i);
        case (sel_e)
            SRC_ZERO: evt_o = strobe_i[STB_ZERO];
            SRC_PRD:  evt_o = strobe_i[STB_PRD];
            SRC_A_UP: evt_o = strobe_i[STB_A_UP];
            SRC_A_DN: evt_o = strobe_i[STB_A_DN];
            SRC_B_UP: evt_o = strobe_i[STB_B_UP];
            SRC_B_DN: evt_o = strobe_i[STB_B_DN];
            default:  evt_o = 1'b0;   // reserved codes
        endcase
    end

endmodule

// File: rtl/evt_cnt_core.sv
module evt_cnt_core #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             frc_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic             irq_o,
    output logic             flag_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] ZERO_C = '0;

    typedef struct packed {
        logic [CNT_W-1:0] prd;
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic             irq;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [CNT_W-1:0] prd_eff;
    logic [CNT_W-1:0] cnt_adv;
    logic             inc;
    logic             fire;

    always_comb begin
        prd_eff = wr_i ? wdata_i : st_q.prd;
        // counts only while below the period now in force; a zero period never counts
        inc     = evt_i && (st_q.cnt < prd_eff);
        cnt_adv = inc ? st_q.cnt + 1'b1 : st_q.cnt;
        fire    = en_i && !st_q.flag && (prd_eff != ZERO_C)
                  && ((cnt_adv == prd_eff) || frc_i);

        st_d      = st_q;
        st_d.prd  = prd_eff;
        st_d.cnt  = fire ? ZERO_C : cnt_adv;
        st_d.flag = fire | (st_q.flag & ~clr_i);
        st_d.irq  = fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o  = st_q.irq;
    assign flag_o = st_q.flag;
    assign cnt_o  = st_q.cnt;

    assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |=> !st_q.irq);

    assert_irq_clears_cnt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> (st_q.cnt == ZERO_C));

    assert_irq_needs_clear_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> (st_q.flag && !$past(st_q.flag)));

    assert_no_irq_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> !st_q.irq);

    assert_no_irq_zero_prd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> (st_q.prd != ZERO_C));

    assert_cnt_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != $past(st_q.cnt)) |->
        ((st_q.cnt == ZERO_C) || (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1))));

endmodule

// File: rtl/evt_irq_prescaler.sv
module evt_irq_prescaler
    import evt_irq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_zero_i,
    input  logic             evt_prd_i,
    input  logic             evt_cmpa_up_i,
    input  logic             evt_cmpa_dn_i,
    input  logic             evt_cmpb_up_i,
    input  logic             evt_cmpb_dn_i,
    input  logic [2:0]       src_sel_i,
    input  logic             irq_en_i,
    input  logic             flag_clr_i,
    input  logic             force_i,
    input  logic             prd_wr_i,
    input  logic [CNT_W-1:0] prd_wdata_i,
    output logic             irq_o,
    output logic             flag_o,
    output logic [CNT_W-1:0] count_o
);

    logic [NUM_SRC-1:0] strobes;
    logic               evt_sel;

    always_comb begin
        strobes           = '0;
        strobes[STB_ZERO] = evt_zero_i;
        strobes[STB_PRD]  = evt_prd_i;
        strobes[STB_A_UP] = evt_cmpa_up_i;
        strobes[STB_A_DN] = evt_cmpa_dn_i;
        strobes[STB_B_UP] = evt_cmpb_up_i;
        strobes[STB_B_DN] = evt_cmpb_dn_i;
    end

    evt_src_sel u_src_sel (
        .strobe_i (strobes),
        .sel_i    (src_sel_i),
        .evt_o    (evt_sel)
    );

    evt_cnt_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_sel),
        .en_i    (irq_en_i),
        .clr_i   (flag_clr_i),
        .frc_i   (force_i),
        .wr_i    (prd_wr_i),
        .wdata_i (prd_wdata_i),
        .irq_o   (irq_o),
        .flag_o  (flag_o),
        .cnt_o   (count_o)
    );

    // reserved codes must not move the count (R1)
    assert_reserved_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_sel_i == 3'b000 || src_sel_i == 3'b011) && !prd_wr_i && !force_i)
        |=> (count_o == $past(count_o)) || (count_o == '0));

endmodule

// File: tb/evt_irq_prescaler_bench.sv
module evt_irq_prescaler_bench;

    localparam int CNT_W = 2;

    typedef struct packed {
        logic [2:0] sel;
        logic [5:0] ev;   // [0]zero [1]prd [2]A up [3]A dn [4]B up [5]B dn
        logic       en;
        logic       clr;
        logic       frc;
        logic       wr;
        logic [1:0] wd;
        logic       x_irq;
        logic       x_flg;
        logic [1:0] x_cnt;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 6'b000000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 2'd0, 4'd3},  // R3 set period 1
        '{3'd1, 6'b000001, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd0, 4'd3},  // R3 first event fires
        '{3'd1, 6'b000000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 4'd3},  // R3 single pulse
        '{3'd1, 6'b000001, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd1, 4'd5},  // R5 counted, held off
        '{3'd1, 6'b000001, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 2'd1, 4'd5},  // R5 holds at period
        '{3'd1, 6'b000000, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 4'd6},  // R6 clear
        '{3'd1, 6'b000000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd0, 4'd6},  // R6 deferred fire
        '{3'd1, 6'b000000, 1'b1, 1'b1, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 2'd0, 4'd6},  // R6 clear, period 3
        '{3'd1, 6'b000010, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd1},  // R1 unselected strobe
        '{3'd2, 6'b000010, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 4'd1},  // R1 period source
        '{3'd3, 6'b111111, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 4'd1},  // R1 reserved 011
        '{3'd4, 6'b000100, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 4'd1},  // R1 A up
        '{3'd5, 6'b001000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 2'd0, 4'd3},  // R3 third event fires
        '{3'd6, 6'b010000, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 4'd1},  // R1 B up with clear
        '{3'd7, 6'b100000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 4'd1},  // R1 B down
        '{3'd7, 6'b000000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1, 2'd0, 4'd8},  // R8 period == count
        '{3'd7, 6'b000000, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd6},  // R6 clear, disable
        '{3'd7, 6'b100000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 4'd2},  // R2 counts disabled
        '{3'd7, 6'b100000, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 4'd2},  // R2 reach, no irq
        '{3'd7, 6'b000000, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 4'd2},  // R2 force disabled
        '{3'd7, 6'b000000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 2'd2, 4'd10}, // R10 period below count
        '{3'd7, 6'b100000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 4'd10}, // R10 holds
        '{3'd7, 6'b100000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 2'd0, 4'd9},  // R9 event with write
        '{3'd7, 6'b000000, 1'b1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd6},  // R6 clear
        '{3'd7, 6'b000000, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 2'd0, 4'd7},  // R7 force
        '{3'd7, 6'b000000, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 4'd4},  // R4 period 00
        '{3'd7, 6'b100000, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd4},  // R4 no counting
        '{3'd7, 6'b000000, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd4},  // R4 force ignored
        '{3'd7, 6'b100000, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 2'd1, 4'd9},  // R9 write from 00
        '{3'd7, 6'b000000, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 2'd0, 4'd7},  // R7 force mid-count
        '{3'd7, 6'b000000, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 2'd0, 4'd5}   // R5 force held off
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] ev = '0;
    logic [2:0] sel = '0;
    logic en = 1'b0, clr = 1'b0, frc = 1'b0, wr = 1'b0;
    logic [CNT_W-1:0] wd = '0;
    logic irq, flg;
    logic [CNT_W-1:0] cnt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    evt_irq_prescaler #(.CNT_W(CNT_W)) u_evt_irq_prescaler (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_zero_i    (ev[0]),
        .evt_prd_i     (ev[1]),
        .evt_cmpa_up_i (ev[2]),
        .evt_cmpa_dn_i (ev[3]),
        .evt_cmpb_up_i (ev[4]),
        .evt_cmpb_dn_i (ev[5]),
        .src_sel_i     (sel),
        .irq_en_i      (en),
        .flag_clr_i    (clr),
        .force_i       (frc),
        .prd_wr_i      (wr),
        .prd_wdata_i   (wd),
        .irq_o         (irq),
        .flag_o        (flg),
        .count_o       (cnt)
    );

    task automatic check(input string req, input logic x_irq, input logic x_flg,
                         input logic [1:0] x_cnt);
        checks++;
        if (irq !== x_irq || flg !== x_flg || cnt !== x_cnt) begin
            failures++;
            $display("FAIL %s: irq/flag/count got %b/%b/%0d expected %b/%b/%0d",
                     req, irq, flg, cnt, x_irq, x_flg, x_cnt);
        end
    endtask

    task automatic idle_inputs();
        ev = '0; clr = 1'b0; frc = 1'b0; wr = 1'b0; wd = '0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R11 reset state", 1'b0, 1'b0, 2'd0);
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            sel = VECS[i].sel; ev = VECS[i].ev; en = VECS[i].en;
            clr = VECS[i].clr; frc = VECS[i].frc; wr = VECS[i].wr; wd = VECS[i].wd;
            @(posedge clk);
            #1 check($sformatf("R%0d vector %0d", VECS[i].req, i),
                     VECS[i].x_irq, VECS[i].x_flg, VECS[i].x_cnt);
        end

        // flag still set, period 2: count advances while held off
        @(negedge clk); idle_inputs(); sel = 3'd7; ev = 6'b100000;
        @(posedge clk); #1 check("R5 count while pending", 1'b0, 1'b1, 2'd1);

        // asynchronous reset mid-run
        @(negedge clk); idle_inputs(); rst_n = 1'b0;
        #1 check("R11 async reset", 1'b0, 1'b0, 2'd0);
        @(negedge clk) rst_n = 1'b1;

        // period returns to 00 after reset: no counting
        @(negedge clk); sel = 3'd7; ev = 6'b100000;
        @(posedge clk); #1 check("R4 reset period is 00", 1'b0, 1'b0, 2'd0);

        // write 01 with a coincident event fires on the first event
        @(negedge clk); ev = 6'b100000; wr = 1'b1; wd = 2'd1;
        @(posedge clk); #1 check("R9 coincident write fires", 1'b1, 1'b1, 2'd0);

        @(negedge clk); idle_inputs();
        @(posedge clk); #1 check("R3 pulse ends", 1'b0, 1'b1, 2'd0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not complete");
            summary();
            $finish;
        end
    end

endmodule